// File: doc/BRIEF.md
# UART 16x Sampling Tick Generator with High-Speed Divide

This block turns a programmable 16-bit divisor into a one-cycle enable pulse at sixteen times the serial bit rate. The transmitter and receiver of a UART use this pulse for their oversampling. The block runs on a 7.3728 MHz reference clock. In the normal interpretation, the divisor N counts in units of four reference cycles, which equals a 1.8432 MHz base. With that base, divisor 2304 gives 50 baud, divisor 12 gives 9600 baud and divisor 1 gives 115200 baud.

A separate high-speed configuration input changes what the divisor's top bit means. With high-speed set and divisor bit 15 at 1, the lower 15 bits count single reference cycles. Divisor 32770 then gives 230400 baud and divisor 32769 gives 460800 baud. Without high-speed, the same value is an ordinary very slow divide.

The divisor and the high-speed bit are captured together on a load strobe. Each load restarts the count, so no period of mixed length is produced. A divisor that works out to zero stops the pulse.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, `tick16x` is 0 and stays 0 until the first `divLoad`.
- R2: With `highSpeed`=0 and divisor N (1..32767) loaded, `tick16x` pulses once every 4*N clock cycles.
- R3: With `highSpeed`=1 and divisor bit 15 = 1, `tick16x` pulses once every M clock cycles, where M is divisor bits 14:0. So 32770 gives a period of 2 and 32769 gives a period of 1.
- R4: With `highSpeed`=0, a divisor with bit 15 = 1 is an ordinary divide with a period of 4*divisor, which is at least 131072 cycles. It never uses the fast interpretation.
- R5: With `highSpeed`=1 and divisor bit 15 = 0, the period is 4*N, as in R2.
- R6: An effective period of zero (divisor 0, or divisor 32768 with `highSpeed`=1) keeps `tick16x` at 0.
- R7: A `divLoad` sampled at clock edge L forces `tick16x` to 0 after edge L. The first pulse then appears after edge L+P, where P is the new period.
- R8: Each pulse lasts one cycle when P > 1. When P = 1, `tick16x` stays high every cycle.
- R9: Changes on `divisor` or `highSpeed` without `divLoad` have no effect on the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 7.3728 MHz reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| divisor | input | 16 | Divisor value, captured on `divLoad` |
| divLoad | input | 1 | Load strobe: captures divisor and high-speed bit, restarts the count |
| highSpeed | input | 1 | High-speed configuration bit, captured on `divLoad` |
| tick16x | output | 1 | 16x sampling enable pulse |

## Verification
The divide is tried with the normal-mode anchor divisors 1 and 12, and with the two high-speed codes 32770 and 32769. These four separate the 4x-scaled path from the fast path. Random small divisors go through both paths, with the high-speed bit both set and clear. This tells apart a wrong scale factor, an off-by-one in the wrap and a wrong choice of which bit selects the fast path. Zero-period codes, a reload partway through a period and divisor changes without a load expose any stale count or any leakage of unlatched inputs.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

  // Strobes from the control half to the counting datapath.
  typedef struct packed {
    logic restart;  // clear count and suppress the pulse this cycle
    logic run;      // a nonzero period is in force
  } tickStrobe_t;

endpackage

// File: rtl/baud_tick_ctrl.sv
module baud_tick_ctrl
  import baud_tick_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int PRESCALE = 4,
  parameter int CNT_W    = DIV_W + $clog2(PRESCALE)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic             divLoad,
  input  logic             highSpeed,
  output tickStrobe_t      strobe,
  output logic [CNT_W-1:0] curPeriod
);

  localparam int HS_BIT = DIV_W - 1;
  localparam int PS_W   = $clog2(PRESCALE);
  localparam bit PS_POW2 = (PRESCALE == (1 << PS_W));

  logic [DIV_W-1:0] divReg;
  logic             hsReg;
  logic             hsSel;
  logic [CNT_W-1:0] scaledPeriod;
  logic [CNT_W-1:0] fastPeriod;

  // Divisor and high-speed bit are taken together on a load.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg <= '0;
      hsReg  <= 1'b0;
    end else if (divLoad) begin
      divReg <= divisor;
      hsReg  <= highSpeed;
    end
  end

  // Normal path: period counted in prescaled units of the reference.
  generate
    if (PS_POW2) begin : g_shiftScale
      always_comb scaledPeriod = CNT_W'(divReg) << PS_W;
    end else begin : g_mulScale
      always_comb scaledPeriod = CNT_W'(divReg) * CNT_W'(PRESCALE);
    end
  endgenerate

  // Fast path: lower bits count single reference cycles.
  always_comb begin
    hsSel      = hsReg & divReg[HS_BIT];
    fastPeriod = CNT_W'(divReg[HS_BIT-1:0]);
    curPeriod  = hsSel ? fastPeriod : scaledPeriod;
  end

  always_comb begin
    strobe.restart = divLoad;
    strobe.run     = (curPeriod != '0);
  end

endmodule

// File: rtl/baud_tick_path.sv
module baud_tick_path
  import baud_tick_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  tickStrobe_t      strobe,
  input  logic [CNT_W-1:0] period,
  output logic             tick
);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] lastCount;
  logic             atWrap;

  always_comb begin
    lastCount = period - CNT_W'(1);
    atWrap    = (count == lastCount);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      tick  <= 1'b0;
    end else if (strobe.restart) begin
      count <= '0;
      tick  <= 1'b0;
    end else if (strobe.run) begin
      if (atWrap) begin
        count <= '0;
        tick  <= 1'b1;
      end else begin
        count <= count + CNT_W'(1);
        tick  <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int PRESCALE = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic             divLoad,
  input  logic             highSpeed,
  output logic             tick16x
);

  localparam int CNT_W = DIV_W + $clog2(PRESCALE);

  tickStrobe_t      strobe;
  logic [CNT_W-1:0] curPeriod;

  baud_tick_ctrl #(
    .DIV_W(DIV_W), .PRESCALE(PRESCALE), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .divisor(divisor), .divLoad(divLoad),
    .highSpeed(highSpeed), .strobe(strobe), .curPeriod(curPeriod)
  );

  baud_tick_path #(.CNT_W(CNT_W)) path_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .period(curPeriod),
    .tick(tick16x)
  );

endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk #(
  parameter int CNT_W = 18
) (
  input logic             clk,
  input logic             rstN,
  input logic             divLoad,
  input logic             tick16x,
  input logic [CNT_W-1:0] curPeriod
);

  logic             seenLoad;
  logic [CNT_W:0]   gap;

  // Cycles since the last load (0 after it) or tick (1 after it).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenLoad <= 1'b0;
      gap      <= '0;
    end else begin
      if (divLoad) seenLoad <= 1'b1;
      if (divLoad)      gap <= '0;
      else if (tick16x) gap <= (CNT_W+1)'(1);
      else              gap <= gap + (CNT_W+1)'(1);
    end
  end

  AST_QUIET_BEFORE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !seenLoad |-> !tick16x);  // R1

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (tick16x && seenLoad) |-> (gap == {1'b0, curPeriod}));  // R2

  AST_ZERO_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (curPeriod == '0) |-> !tick16x);  // R6

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    divLoad |=> !tick16x);  // R7

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (tick16x && !divLoad && curPeriod != CNT_W'(1)) |=> !tick16x);  // R8

  AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !divLoad |=> $stable(curPeriod));  // R9

endmodule

bind baud_tick_gen baud_tick_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .divLoad(divLoad), .tick16x(tick16x),
  .curPeriod(curPeriod)
);

// File: tb/baud_tick_gen_tb_top.sv
module baud_tick_gen_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] divisor = '0;
  logic        divLoad = 1'b0;
  logic        highSpeed = 1'b0;
  logic        tick16x;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  baud_tick_gen dut_i (
    .clk(clk), .rstN(rstN), .divisor(divisor), .divLoad(divLoad),
    .highSpeed(highSpeed), .tick16x(tick16x)
  );

  function automatic int expPeriod(logic [15:0] d, logic hs);
    if (hs && d[15]) return int'(d[14:0]);
    return 4 * int'(d);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic loadDiv(logic [15:0] d, logic hs);
    @(negedge clk);
    divisor = d; highSpeed = hs; divLoad = 1'b1;
    @(negedge clk);
    divLoad = 1'b0;
  endtask

  // Load, then measure first and second pulse positions after the load edge.
  task automatic runPeriod(logic [15:0] d, logic hs, string req);
    int expP = expPeriod(d, hs);
    int first = 0, second = 0, n = 0;
    loadDiv(d, hs);
    check(tick16x == 1'b0, "R7 load clears", int'(tick16x), 0);
    if (expP == 0) begin
      for (int k = 1; k <= 200; k++) begin
        @(negedge clk);
        if (tick16x) n++;
      end
      check(n == 0, {req, " R6 zero period"}, n, 0);
    end else begin
      for (int k = 1; k <= 2 * expP; k++) begin
        @(negedge clk);
        if (tick16x) begin
          n++;
          if (n == 1) first = k;
          if (n == 2) second = k;
        end
      end
      check(first == expP, {req, " R7 first pulse"}, first, expP);
      check(second == 2 * expP, {req, " period"}, second, 2 * expP);
      check(n == 2, {req, " R8 pulse count"}, n, 2);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      finished = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: quiet after reset, before any load
    n = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (tick16x) n++;
    end
    check(n == 0, "R1 no tick before load", n, 0);

    // Directed anchors
    runPeriod(16'd1, 1'b0, "R2 div1");
    runPeriod(16'd12, 1'b0, "R2 div12");
    runPeriod(16'd32770, 1'b1, "R3 hs 32770");
    runPeriod(16'd32769, 1'b1, "R3 hs 32769");
    runPeriod(16'd12, 1'b1, "R5 hs bit15 clear");
    runPeriod(16'd0, 1'b0, "R6 div0");
    runPeriod(16'd32768, 1'b1, "R6 hs 32768");

    // R4: bit 15 without high-speed is a slow divide, no fast pulses
    loadDiv(16'd32769, 1'b0);
    n = 0;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (tick16x) n++;
    end
    check(n == 0, "R4 slow divide with bit15", n, 0);

    // R7: reload partway through a period
    loadDiv(16'd3, 1'b0);
    repeat (5) @(negedge clk);
    runPeriod(16'd1, 1'b0, "R7 midperiod reload");

    // R9: unlatched input changes ignored
    loadDiv(16'd2, 1'b0);
    divisor = 16'd32769; highSpeed = 1'b1;
    begin
      int first = 0, second = 0, cnt = 0;
      for (int k = 1; k <= 16; k++) begin
        @(negedge clk);
        if (tick16x) begin
          cnt++;
          if (cnt == 1) first = k;
          if (cnt == 2) second = k;
        end
      end
      check(first == 8 && second == 16 && cnt == 2, "R9 no change without load",
            second, 16);
    end

    // Random mix across both paths
    for (int i = 0; i < 24; i++) begin
      logic [15:0] d;
      logic hs;
      hs = 1'($urandom_range(0, 1));
      if (hs && $urandom_range(0, 1) == 1)
        d = 16'h8000 | 16'($urandom_range(1, 600));
      else
        d = 16'($urandom_range(1, 150));
      if (hs && d[15]) runPeriod(d, hs, "R3 random");
      else if (hs)     runPeriod(d, hs, "R5 random");
      else             runPeriod(d, hs, "R2 random");
    end

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule